// File: doc/BRIEF.md
# Parallel Port Modulation Router

This block sits between an 18-bit parallel modulation input and the control parameters of a direct digital synthesizer core. Each incoming word carries a 16-bit sample and a 2-bit selector. The selector chooses which synthesizer parameter receives the sample: amplitude, phase, frequency, or a split polar pair. The block produces its own data clock by dividing the core clock by four. It captures the port on each rising edge of that data clock.

A transmit-enable input gates capture. When transmit-enable drops, a configuration bit chooses one of two behaviours for the sample: keep it as it is, or force it to zero. The selector is always kept. A programmable gain shifts frequency samples left inside a 32-bit tuning word. A keying path can override the amplitude output at any time. Configuration goes through a small register-write interface.

The divider runs a four-state machine: `DIV_LO0` to `DIV_LO1` to `DIV_HI0` to `DIV_HI1`, then back to `DIV_LO0`. The capture strobe is active in `DIV_LO1`. The gate runs a two-state machine: `GT_IDLE` moves to `GT_RUN` on a strobe with transmit-enable high, and `GT_RUN` moves to `GT_IDLE` on a strobe with transmit-enable low.

Top module: `ppm_router`

## Requirements
- R1: Port bits [17:2] are the sample and bits [1:0] are the selector: 00 amplitude, 01 phase, 10 frequency, 11 polar.
- R2: `dclk` is low after reset and then repeats two core cycles low and two core cycles high, so its rate is one quarter of the core clock.
- R3: The port is captured on the core edge where `dclk` rises, and the addressed output shows the new value one core cycle later.
- R4: A capture edge with `tx_en` low takes nothing from the port.
- R5: When `tx_en` drops with the zero mode clear (config address 1, bit 0 = 0), all outputs keep their values. In both modes the selector keeps its last value.
- R6: When the zero mode is set, the first capture edge with `tx_en` low after one with it high writes zero to the parameter named by the retained selector.
- R7: A frequency sample appears in `freq_word` shifted left by the gain (config address 0, bits [3:0]). Vacated low bits are zero and bits above 31 are dropped. The gain resets to 0, which gives LSB alignment.
- R8: For a polar word, sample bits [15:8] go to `phase_word[15:8]` and sample bits [7:0] go to `amp_word[15:8]`. The low bytes of both outputs become zero.
- R9: An output that is not the destination of a load keeps its value.
- R10: While keying is enabled (config address 2, bit 0), `amp_word` equals the keying amplitude (config address 3, bits [15:0]). This starts from the cycle after the write, whatever the port routes. Routed amplitude data reappears when keying is disabled.
- R11: Synchronous reset clears all outputs and all configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sample clock |
| rst | input | 1 | Synchronous reset, active high |
| port_in | input | 18 | Sample (upper 16 bits) and selector (lower 2 bits) |
| tx_en | input | 1 | Transmit enable; gates capture |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| dclk | output | 1 | Data clock, one quarter of the core rate |
| freq_word | output | 32 | Frequency tuning word |
| phase_word | output | 16 | Phase offset word |
| amp_word | output | 16 | Amplitude scale word |

## Verification
Two functions can act on `amp_word` in the same cycle: the keying override and a port load aimed at amplitude (directly or through a polar word). The bench turns keying on and then routes amplitude and polar words. It expects `amp_word` to stay at the keying value while the phase byte of the polar word still lands. When keying is turned off, the last routed amplitude must show. The zero mode has a similar collision: a falling `tx_en` edge carries a port selector that differs from the retained one. The check confirms that the zero lands on the retained parameter only.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
    typedef enum logic [1:0] {
        DST_AMP = 2'b00,
        DST_PHS = 2'b01,
        DST_FRQ = 2'b10,
        DST_POL = 2'b11
    } dest_e;

    typedef enum logic [1:0] {
        DIV_LO0,
        DIV_LO1,
        DIV_HI0,
        DIV_HI1
    } div_e;

    typedef enum logic {
        GT_IDLE,
        GT_RUN
    } gate_e;

    localparam logic [1:0] CFG_GAIN = 2'd0;
    localparam logic [1:0] CFG_ZERO = 2'd1;
    localparam logic [1:0] CFG_KEYE = 2'd2;
    localparam logic [1:0] CFG_KEYA = 2'd3;
endpackage

// File: rtl/ppm_clkdiv.sv
module ppm_clkdiv
    import ppm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic dclk,
    output logic cap
);
    div_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= DIV_LO0;
        else     st <= st_nx;
    end

    always_comb begin
        unique case (st)
            DIV_LO0: st_nx = DIV_LO1;
            DIV_LO1: st_nx = DIV_HI0;
            DIV_HI0: st_nx = DIV_HI1;
            DIV_HI1: st_nx = DIV_LO0;
        endcase
    end

    always_comb begin
        dclk = (st == DIV_HI0) || (st == DIV_HI1);
        cap  = (st == DIV_LO1);
    end

    AST_CAP_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        cap |=> $rose(dclk)); // R2
    AST_DCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk) |=> dclk); // R2
    AST_DCLK_LOW_TWO: assert property (@(posedge clk) disable iff (rst)
        $fell(dclk) |=> !dclk); // R2
endmodule

// File: rtl/ppm_gate.sv
module ppm_gate
    import ppm_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 2,
    localparam int PW = DW + SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap,
    input  logic          tx_en,
    input  logic          zero_mode,
    input  logic [PW-1:0] port_in,
    output logic [DW-1:0] data_q,
    output dest_e         dest_q,
    output logic          ld
);
    gate_e st, st_nx;

    always_ff @(posedge clk) begin
        if (rst) st <= GT_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        if (cap) begin
            unique case (st)
                GT_IDLE: st_nx = tx_en ? GT_RUN : GT_IDLE;
                GT_RUN:  st_nx = tx_en ? GT_RUN : GT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dest_q <= DST_AMP;
            ld     <= 1'b0;
        end else begin
            ld <= 1'b0;
            if (cap) begin
                if (tx_en) begin
                    data_q <= port_in[PW-1:SW];
                    dest_q <= dest_e'(port_in[SW-1:0]);
                    ld     <= 1'b1;
                end else if (st == GT_RUN && zero_mode) begin
                    data_q <= '0;
                    ld     <= 1'b1;
                end
            end
        end
    end

    AST_IDLE_DEST_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cap && !tx_en) |=> $stable(dest_q)); // R5
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cap && !tx_en && !zero_mode) |=> !ld); // R5
    AST_LOAD_ON_CAP: assert property (@(posedge clk) disable iff (rst)
        ld |-> $past(cap)); // R3
    AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cap && !tx_en && zero_mode && st == GT_RUN) |=> (ld && data_q == '0)); // R6
endmodule

// File: rtl/ppm_route.sv
module ppm_route
    import ppm_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 32,
    parameter int GW = 4,
    localparam int HW = DW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [DW-1:0] data,
    input  dest_e         dest,
    input  logic [GW-1:0] gain,
    input  logic          key_en,
    input  logic [DW-1:0] key_amp,
    output logic [FW-1:0] freq_word,
    output logic [DW-1:0] phase_word,
    output logic [DW-1:0] amp_word
);
    logic [FW-1:0] frq_r;
    logic [DW-1:0] phs_r, amp_r;
    logic [FW-1:0] frq_ext;

    assign frq_ext = {{(FW-DW){1'b0}}, data};

    always_ff @(posedge clk) begin
        if (rst) begin
            frq_r <= '0;
            phs_r <= '0;
            amp_r <= '0;
        end else if (ld) begin
            unique case (dest)
                DST_AMP: amp_r <= data;
                DST_PHS: phs_r <= data;
                DST_FRQ: frq_r <= frq_ext << gain;
                DST_POL: begin
                    phs_r <= {data[DW-1:HW], {HW{1'b0}}};
                    amp_r <= {data[HW-1:0], {HW{1'b0}}};
                end
            endcase
        end
    end

    always_comb begin
        freq_word  = frq_r;
        phase_word = phs_r;
        amp_word   = key_en ? key_amp : amp_r;
    end

    AST_FRQ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ld && dest == DST_FRQ) |=> ($stable(phs_r) && $stable(amp_r))); // R9
    AST_AMP_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ld && dest == DST_AMP) |=> ($stable(phs_r) && $stable(frq_r))); // R9
    AST_FRQ_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ld && dest == DST_FRQ && gain != '0) |=> (frq_r[0] == 1'b0)); // R7
    AST_POL_LOW_BYTES: assert property (@(posedge clk) disable iff (rst)
        (ld && dest == DST_POL) |=> (phs_r[HW-1:0] == '0 && amp_r[HW-1:0] == '0)); // R8
    AST_NO_LOAD_STILL: assert property (@(posedge clk) disable iff (rst)
        !ld |=> ($stable(frq_r) && $stable(phs_r) && $stable(amp_r))); // R4
endmodule

// File: rtl/ppm_router.sv
module ppm_router
    import ppm_pkg::*;
#(
    parameter int DW = 16,
    parameter int SW = 2,
    parameter int FW = 32,
    parameter int GW = 4,
    parameter int AW = 2,
    localparam int PW = DW + SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] port_in,
    input  logic          tx_en,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          dclk,
    output logic [FW-1:0] freq_word,
    output logic [DW-1:0] phase_word,
    output logic [DW-1:0] amp_word
);
    logic [GW-1:0] gain_r;
    logic          zero_r, keye_r;
    logic [DW-1:0] keya_r;
    logic          cap, ld;
    logic [DW-1:0] data_q;
    dest_e         dest_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_r <= '0;
            zero_r <= 1'b0;
            keye_r <= 1'b0;
            keya_r <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_GAIN: gain_r <= cfg_wdata[GW-1:0];
                CFG_ZERO: zero_r <= cfg_wdata[0];
                CFG_KEYE: keye_r <= cfg_wdata[0];
                CFG_KEYA: keya_r <= cfg_wdata;
            endcase
        end
    end

    ppm_clkdiv u_div (
        .clk  (clk),
        .rst  (rst),
        .dclk (dclk),
        .cap  (cap)
    );

    ppm_gate #(.DW(DW), .SW(SW)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .tx_en     (tx_en),
        .zero_mode (zero_r),
        .port_in   (port_in),
        .data_q    (data_q),
        .dest_q    (dest_q),
        .ld        (ld)
    );

    ppm_route #(.DW(DW), .FW(FW), .GW(GW)) u_route (
        .clk        (clk),
        .rst        (rst),
        .ld         (ld),
        .data       (data_q),
        .dest       (dest_q),
        .gain       (gain_r),
        .key_en     (keye_r),
        .key_amp    (keya_r),
        .freq_word  (freq_word),
        .phase_word (phase_word),
        .amp_word   (amp_word)
    );

    AST_KEY_WINS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_KEYE && cfg_wdata[0]) |=> (amp_word == keya_r)); // R10
endmodule

// File: tb/sim_ppm_router.sv
module sim_ppm_router;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] port_in = '0;
    logic        tx_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        dclk;
    logic [31:0] freq_word;
    logic [15:0] phase_word, amp_word;

    int checks = 0;
    int fails = 0;

    logic [31:0] e_frq;
    logic [15:0] e_phs, e_amp, e_key;
    logic [1:0]  e_dest;
    logic [3:0]  e_gain;
    logic        e_zero, e_keye, e_run;

    always #10 clk = ~clk;

    ppm_router u0 (
        .clk(clk), .rst(rst), .port_in(port_in), .tx_en(tx_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dclk(dclk), .freq_word(freq_word), .phase_word(phase_word),
        .amp_word(amp_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, freq_word, e_frq);
        chk(req, {16'h0, phase_word}, {16'h0, e_phs});
        chk(req, {16'h0, amp_word}, {16'h0, e_keye ? e_key : e_amp});
    endtask

    task automatic apply(input logic [15:0] d);
        case (e_dest)
            2'b00: e_amp = d;
            2'b01: e_phs = d;
            2'b10: e_frq = {16'h0, d} << e_gain;
            default: begin
                e_phs = {d[15:8], 8'h00};
                e_amp = {d[7:0], 8'h00};
            end
        endcase
    endtask

    task automatic wait_rise();
        logic prev;
        prev = dclk;
        @(negedge clk);
        while (!(prev == 1'b0 && dclk == 1'b1)) begin
            prev = dclk;
            @(negedge clk);
        end
    endtask

    task automatic send(input logic [15:0] d, input logic [1:0] dst, input logic en);
        port_in = {d, dst};
        tx_en = en;
        if (en) begin
            e_dest = dst;
            apply(d);
            e_run = 1'b1;
        end else begin
            if (e_run && e_zero) apply(16'h0);
            e_run = 1'b0;
        end
        wait_rise();
        @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0: e_gain = d[3:0];
            2'd1: e_zero = d[0];
            2'd2: e_keye = d[0];
            default: e_key = d;
        endcase
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        e_frq = 0; e_phs = 0; e_amp = 0; e_key = 0; e_dest = 0;
        e_gain = 0; e_zero = 0; e_keye = 0; e_run = 0;
        repeat (3) @(negedge clk);
        // R11 reset state; R2 data clock starts low
        chk("R11", {dclk, freq_word[30:0]}, 32'h0);
        chk_all("R11");
        rst = 1'b0;

        // R2: quarter-rate, two low then two high
        begin
            int highs = 0;
            int rises = 0;
            logic p = 1'b0;
            for (int i = 0; i < 16; i++) begin
                @(negedge clk);
                if (dclk) highs++;
                if (dclk && !p) rises++;
                if (i < 2) chk("R2", {31'h0, dclk}, {31'h0, i == 1});
                p = dclk;
            end
            chk("R2", highs, 8);
            chk("R2", rises, 4);
        end

        // R1 R3 R9: amplitude and phase sweeps
        for (int i = 0; i < 16; i++) begin
            send(16'(i * 16'h1111) ^ 16'h0F0F, 2'b00, 1'b1);
            chk_all("R1 R3 R9 amp");
            send(16'(i * 16'h0123) + 16'h8000, 2'b01, 1'b1);
            chk_all("R1 R3 R9 phase");
        end

        // R7: every gain against several samples
        for (int g = 0; g < 16; g++) begin
            cfg(2'd0, 16'(g));
            send(16'hFFFF, 2'b10, 1'b1);
            chk_all("R7 gain");
            send(16'h8001, 2'b10, 1'b1);
            chk_all("R7 gain");
            send(16'(16'h1234 + g), 2'b10, 1'b1);
            chk_all("R7 gain");
        end
        cfg(2'd0, 16'h0);
        send(16'h00A5, 2'b10, 1'b1);
        chk("R7 lsb", freq_word, 32'h0000_00A5);

        // R8: polar split
        for (int i = 0; i < 8; i++) begin
            send(16'(i * 16'h2357) ^ 16'hA55A, 2'b11, 1'b1);
            chk_all("R8 polar");
        end

        // R4 R5: hold mode, port changes ignored, selector kept
        send(16'h4321, 2'b01, 1'b1);
        send(16'hDEAD, 2'b10, 1'b0);
        chk_all("R4 R5 hold");
        send(16'hBEEF, 2'b00, 1'b0);
        chk_all("R4 R5 hold");

        // R6 R5: zero mode, zero goes to retained frequency selector
        cfg(2'd1, 16'h1);
        send(16'h7777, 2'b10, 1'b1);
        chk_all("R6 pre");
        send(16'h5555, 2'b00, 1'b0);
        chk("R6 zero", freq_word, 32'h0);
        chk_all("R5 R6 retained");
        send(16'h6666, 2'b01, 1'b0);
        chk_all("R4 idle");
        send(16'h1357, 2'b01, 1'b1);
        send(16'h0000, 2'b11, 1'b0);
        chk("R6 phase zero", {16'h0, phase_word}, 32'h0);
        cfg(2'd1, 16'h0);

        // R10: keying override against routed amplitude and polar words
        send(16'h1111, 2'b00, 1'b1);
        cfg(2'd3, 16'hBEEF);
        cfg(2'd2, 16'h1);
        chk("R10 key", {16'h0, amp_word}, 32'h0000_BEEF);
        send(16'h2222, 2'b00, 1'b1);
        chk_all("R10 key amp");
        send(16'hC3A9, 2'b11, 1'b1);
        chk_all("R10 key polar");
        chk("R10 polar phase", {16'h0, phase_word}, 32'h0000_C300);
        cfg(2'd2, 16'h0);
        chk("R10 release", {16'h0, amp_word}, 32'h0000_A900);

        // R11 again: reset clears config and outputs
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_frq = 0; e_phs = 0; e_amp = 0; e_key = 0; e_dest = 0;
        e_gain = 0; e_zero = 0; e_keye = 0; e_run = 0;
        chk_all("R11 rerun");
        send(16'h0001, 2'b10, 1'b1);
        chk("R11 gain reset", freq_word, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule